// File: doc/BRIEF.md
# Rotating-Priority Four-Way Request Arbiter

This block merges four independent producer streams onto one consumer stream. Each producer offers a word with a valid/ready handshake. In each cycle the block chooses at most one of the offering producers and moves its word into a registered output stage. The consumer drains that stage with its own valid/ready handshake.

The choice comes from a two-bit rotation pointer that names the channel searched first. The search then walks upward through the channel indices and wraps past the last one. The pointer moves forward by exactly one step each time the consumer takes a word, whichever channel supplied it. Priority therefore sweeps all four channels in a fixed cycle and never jumps to the channel after the last winner.

When the consumer takes a word in the same cycle that a new word is chosen, the search already starts from the advanced pointer value. A steady stream with all four channels busy thus serves them strictly in turn.

Top module: `rot_arb4`

## Requirements
- R1: After reset the output valid is low and the rotation pointer is 0, so the first choice with every channel offering is channel 0.
- R2: The search starts at the channel whose index equals the search base and continues at base+1, base+2 and base+3, each modulo 4. The first offering channel in that order is chosen. Channel i's word sits at bits [i*DATA_W +: DATA_W] of the packed input bus.
- R3: At most one input ready bit is high in any cycle. It is high only for a channel whose valid is high, and only while the output ready is high.
- R4: A word accepted on an input appears on the output, with output valid high, in the next cycle.
- R5: While output valid is high and output ready is low, the output word and valid hold and no input is accepted.
- R6: Each cycle with output valid and output ready both high advances the pointer by one, with 3 wrapping to 0. The search base in that same cycle is the advanced value. With all channels offering and the consumer always ready, the grants run 0,1,2,3,0,...
- R7: In a cycle without an output handshake the pointer holds, and the search base equals the pointer.
- R8: When output ready is high and no channel offers, output valid is low in the next cycle.
- R9: Acceptance stays blocked until two clock edges after the asynchronous reset input is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in sync with clk |
| in_valid | input | NUM_CH | Per-channel offer |
| in_ready | output | NUM_CH | Per-channel accept, at most one bit high |
| in_data | input | NUM_CH*DATA_W | Packed channel words, channel i at [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Registered output word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | DATA_W | Registered output word |

## Verification
The arbiter is driven with all four channels offering under a permanently ready consumer, which exposes the fixed 0,1,2,3 sweep and its wrap. Single-channel offers at every position show that the search wraps from any base. Stalls with channels offering separate holding from re-choosing, and idle cycles show the pointer holding and the output draining. Long random mixes of offer masks and consumer backpressure are compared against a bench-side model of the pointer, the search and the output stage, which catches errors in the choice and errors in the look-ahead base.

// File: rtl/rot_arb_pkg.sv
package rot_arb_pkg;

  // Width helper for channel indices; one bit minimum so a single-channel
  // build still elaborates.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Result of the rotating search.
  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
  } pick_t;

endpackage

// File: rtl/rot_arb_rst_sync.sv
module rot_arb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/rot_arb_ptr.sv
module rot_arb_ptr #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PTR_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] ptr_inc
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

  logic [PTR_W-1:0] ptr_nxt;

  // Incremented value with wrap, also used as the look-ahead search base.
  always_comb begin
    if (ptr_q == LAST) begin
      ptr_inc = '0;
    end else begin
      ptr_inc = ptr_q + PTR_W'(1);
    end
  end

  always_comb begin
    ptr_nxt = ptr_q;
    if (adv) begin
      ptr_nxt = ptr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_nxt;
    end
  end

endmodule

// File: rtl/rot_arb_pick.sv
module rot_arb_pick #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PTR_W  = 2
) (
  input  logic [PTR_W-1:0]  base,
  input  logic [NUM_CH-1:0] req,
  output logic              hit,
  output logic [PTR_W-1:0]  idx,
  output logic [NUM_CH-1:0] onehot
);

  // Requests rotated so that position 0 is the channel named by base.
  logic [NUM_CH-1:0] rot_req;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_rot
    always_comb begin
      int unsigned pos;
      pos = (int'(base) + k) % NUM_CH;
      rot_req[k] = req[pos];
    end
  end

  // Lowest rotated position wins; map it back to an absolute channel.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (rot_req[k]) begin
        hit = 1'b1;
        idx = PTR_W'((int'(base) + k) % NUM_CH);
      end
    end
  end

  always_comb begin
    onehot = '0;
    if (hit) begin
      onehot[idx] = 1'b1;
    end
  end

endmodule

// File: rtl/rot_arb_oreg.sv
module rot_arb_oreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              hit,
  input  logic [DATA_W-1:0] din,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              valid_nxt;
  logic [DATA_W-1:0] data_nxt;
  logic              data_en;

  always_comb begin
    valid_nxt = out_valid;
    data_nxt  = out_data;
    data_en   = 1'b0;
    if (load) begin
      valid_nxt = hit;
      if (hit) begin
        data_nxt = din;
        data_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (data_en) begin
      out_data <= data_nxt;
    end
  end

endmodule

// File: rtl/rot_arb4.sv
module rot_arb4 #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          in_valid,
  output logic [NUM_CH-1:0]          in_ready,
  input  logic [NUM_CH*DATA_W-1:0]   in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_data
);

  import rot_arb_pkg::*;

  localparam int unsigned PTR_W = idx_width(NUM_CH);

  logic              srst_n;
  logic              fire_out;
  logic              load;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_inc;
  logic [PTR_W-1:0]  base;
  logic              pick_hit;
  logic [PTR_W-1:0]  pick_idx;
  logic [NUM_CH-1:0] pick_oh;
  logic [DATA_W-1:0] chan_word [NUM_CH];
  logic [DATA_W-1:0] sel_word;

  rot_arb_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Consumer takes the current word this cycle.
  assign fire_out = out_valid & out_ready;

  rot_arb_ptr #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (srst_n),
    .adv     (fire_out),
    .ptr_q   (ptr_q),
    .ptr_inc (ptr_inc)
  );

  // Look ahead: search from the value the pointer takes after this handshake.
  assign base = fire_out ? ptr_inc : ptr_q;

  rot_arb_pick #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_pick (
    .base   (base),
    .req    (in_valid),
    .hit    (pick_hit),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  // Output stage reloads only while the consumer is ready and reset is over.
  assign load     = out_ready & srst_n;
  assign in_ready = load ? pick_oh : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slice
    assign chan_word[c] = in_data[c*DATA_W +: DATA_W];
  end

  assign sel_word = chan_word[pick_idx];

  rot_arb_oreg #(.DATA_W(DATA_W)) u_oreg (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (load),
    .hit       (pick_hit),
    .din       (sel_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/rot_arb4_chk.sv
module rot_arb4_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 2
) (
  input logic              clk,
  input logic              srst_n,
  input logic [NUM_CH-1:0] in_valid,
  input logic [NUM_CH-1:0] in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [PTR_W-1:0]  ptr
);

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(in_ready));

  // R3
  grant_needs_oready_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|in_ready) |-> out_ready);

  // R3
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((in_ready & ~in_valid) == '0));

  // R4
  accept_shows_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|in_ready) |=> out_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && out_ready) |=> (int'(ptr) == (int'($past(ptr)) + 1) % NUM_CH));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(out_valid && out_ready) |=> $stable(ptr));

  // R8
  idle_drain_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_ready && !(|in_valid)) |=> !out_valid);

  // R9
  reset_block_chk: assert property (@(posedge clk)
    !srst_n |-> (in_ready == '0));

endmodule

bind rot_arb4 rot_arb4_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .PTR_W  (PTR_W)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .ptr       (ptr_q)
);

// File: tb/rot_arb4_bench.sv
module rot_arb4_bench;

  localparam int NCH = 4;
  localparam int DW  = 32;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    in_valid;
  logic [NCH-1:0]    in_ready;
  logic [NCH*DW-1:0] in_data;
  logic              out_valid;
  logic              out_ready;
  logic [DW-1:0]     out_data;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench model state
  int          m_ptr;
  logic        m_ov;
  logic [DW-1:0] m_od;

  rot_arb4 #(.NUM_CH(NCH), .DATA_W(DW)) u_rot_arb4 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Rotating search from base; returns -1 when nothing offers.
  function automatic int exp_pick(input int base, input logic [NCH-1:0] v);
    for (int k = 0; k < NCH; k++) begin
      if (v[(base + k) % NCH]) return (base + k) % NCH;
    end
    return -1;
  endfunction

  task automatic step(input logic [NCH-1:0] v, input logic r, input string tag);
    int g;
    int base;
    bit fire;
    logic [NCH-1:0] exp_rdy;
    @(negedge clk);
    check(out_valid === m_ov, tag, "out_valid", 64'(out_valid), 64'(m_ov));
    if (m_ov) check(out_data === m_od, tag, "out_data", 64'(out_data), 64'(m_od));
    in_valid  = v;
    out_ready = r;
    for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = $urandom;
    #1;
    fire = m_ov && r;
    base = (m_ptr + (fire ? 1 : 0)) % NCH;
    g = exp_pick(base, v);
    exp_rdy = '0;
    if (r && g >= 0) exp_rdy[g] = 1'b1;
    check(in_ready === exp_rdy, tag, "in_ready", 64'(in_ready), 64'(exp_rdy));
    if (fire) m_ptr = (m_ptr + 1) % NCH;
    if (r) begin
      m_ov = (g >= 0);
      if (g >= 0) m_od = in_data[g*DW +: DW];
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n     = 1'b0;
    in_valid  = '0;
    out_ready = 1'b0;
    in_data   = '0;
    m_ptr = 0;
    m_ov  = 1'b0;
    m_od  = '0;
    repeat (4) @(negedge clk);
    // R9: offer everything right at release; nothing may be accepted yet
    rst_n     = 1'b1;
    in_valid  = '1;
    out_ready = 1'b1;
    #1;
    check(in_ready === '0, "R9", "in_ready at release", 64'(in_ready), 64'd0);
    @(negedge clk);
    check(in_ready === '0, "R9", "in_ready one edge after", 64'(in_ready), 64'd0);
    in_valid  = '0;
    out_ready = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    step(4'b1111, 1'b1, "R1");            // channel 0 first
    // R6: fixed sweep 1,2,3,0,1,2 with wrap
    for (int i = 0; i < 6; i++) step(4'b1111, 1'b1, "R6");
    // R5: stall with channels offering
    for (int i = 0; i < 3; i++) step(4'b1111, 1'b0, "R5");
    step(4'b1111, 1'b1, "R6");
    // R2: single offers at each position, from shifting bases
    for (int i = 0; i < NCH; i++) step(4'(1 << i), 1'b1, "R2");
    step(4'b1000, 1'b1, "R2");
    step(4'b0001, 1'b1, "R2");
    step(4'b0110, 1'b1, "R2");
    // R8 and R7: idle drain, pointer holds
    step(4'b0000, 1'b1, "R8");
    step(4'b0000, 1'b1, "R8");
    step(4'b0000, 1'b0, "R7");
    step(4'b1010, 1'b0, "R7");
    step(4'b1111, 1'b1, "R7");
    step(4'b1111, 1'b1, "R4");
    // R3: random mix of offers and backpressure
    for (int i = 0; i < 4000; i++) begin
      logic [NCH-1:0] v;
      logic r;
      v = NCH'($urandom);
      r = (($urandom % 4) != 0);
      step(v, r, "R3");
    end
    step(4'b0000, 1'b1, "R8");
    step(4'b0000, 1'b1, "R8");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule